// File: doc/BRIEF.md
# Configuration Address Translating Bridge

This block sits between a simple memory-mapped host register bus and a configuration access port on an expansion bus. The host sees two 4 KB windows. The decoder upstream picks the window; this block receives the window select and the three lowest offset bits. A write to the address window loads a 32-bit configuration address register. A read from that window returns the register unchanged.

An access to the data window becomes one configuration cycle on the downstream port. The block rewrites the stored address into the conventional register/function/slot layout. It recognises three host formats, checked in a fixed priority: a raw pass-through form marked by bit 31, a type-1 form marked by bit 0, and a type-0 form. In the type-0 form the slot is given as a one-hot select line among address bits [31:11].

The host is big-endian and the port is little-endian, so data is byte-reversed within the access width in both directions. The host bus is held in a wait state until the downstream target acknowledges.

Top module: `cfgx_bridge`

## Requirements
- R1: A host write to the address window (`hb_win`=0) stores `hb_wdata` in the configuration address register. A host read of that window returns the register unchanged. Any other access leaves the register unchanged.
- R2: After reset the configuration address register reads zero and `cf_req` is low. A request that is pending at reset is dropped.
- R3: If stored bit 31 is 1, the downstream address is the stored value with bits [1:0] replaced by `hb_lo[1:0]`.
- R4: If stored bit 31 is 0 and bit 0 is 1, the downstream address is the stored value with bits [2:0] replaced by `hb_lo[2:0]`.
- R5: If stored bits 31 and 0 are both 0, the address is built as follows. Bits [2:0] are `hb_lo`. Bits [7:3] are stored bits [7:3]. Bits [10:8] are stored bits [10:8]. Bits [15:11] hold the index (11 to 31) of the lowest set stored bit within [31:11]. Bits [31:16] are zero.
- R6: In the type-0 form with no bit of [31:11] set, no downstream request is issued. A read then returns 32'hFFFF_FFFF, and a write is dropped.
- R7: The size code `hb_size` means 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. Write data goes out on `cf_wdata` as follows. One byte gives {24'h0, d[7:0]}. Two bytes give {16'h0, d[7:0], d[15:8]}. Four bytes give all four bytes in reversed order.
- R8: Read data from `cf_rdata` is returned on `hb_rdata` with the same size-dependent reversal and zero fill as in R7.
- R9: Each data-window access that selects a device raises `cf_req` exactly once. `cf_addr`, `cf_we`, `cf_len` and `cf_wdata` stay stable until the cycle in which `cf_ack` is high. `cf_req` then drops, and `hb_ready` is high for exactly one cycle on the following clock.
- R10: `cf_len` carries the host's `hb_size` code and `cf_we` carries `hb_we` of the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_sel | input | 1 | Host access valid; held until `hb_ready` |
| hb_win | input | 1 | Window: 0 address register, 1 data |
| hb_we | input | 1 | Host write |
| hb_lo | input | 3 | Lowest offset bits within the window |
| hb_size | input | 2 | Access size code |
| hb_wdata | input | 32 | Host write data |
| hb_rdata | output | 32 | Host read data, valid with `hb_ready` |
| hb_ready | output | 1 | One-cycle access completion |
| cf_req | output | 1 | Downstream configuration request |
| cf_we | output | 1 | Downstream write |
| cf_len | output | 2 | Downstream size code |
| cf_addr | output | 32 | Translated configuration address |
| cf_wdata | output | 32 | Byte-reversed write data |
| cf_ack | input | 1 | Downstream acknowledge |
| cf_rdata | input | 32 | Downstream read data, valid with `cf_ack` |

## Verification
Two things can happen in the same cycle: the request appears, and the target answers it. A target with zero latency raises `cf_ack` in the first cycle `cf_req` is high. The read data must then be captured and the request retired in one step. The bench's target model picks a random latency of 0 to 2 cycles for each request, so zero-latency answers occur often. For every access the bench checks the returned data and the request fields against reference functions. It also checks that exactly one request was counted per access.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } cfgx_state_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WORD_ALT = 2'd3
  } cfgx_size_e;
endpackage

// File: rtl/cfgx_addr_xlate.sv
module cfgx_addr_xlate #(
  parameter int ADDR_W   = 32,
  parameter int LOW_SLOT = 11
) (
  input  logic [ADDR_W-1:0] cfg_reg,
  input  logic [2:0]        lo,
  output logic [ADDR_W-1:0] xaddr,
  output logic              nodev
);
  localparam int IDX_W = $clog2(ADDR_W);

  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [ADDR_W-1:0] t0_addr;

  // lowest set bit among the select lines wins
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = ADDR_W - 1; i >= LOW_SLOT; i--) begin
      if (cfg_reg[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    t0_addr = '0;
    t0_addr[2:0] = lo;
    t0_addr[7:3] = cfg_reg[7:3];
    t0_addr[10:8] = cfg_reg[10:8];
    t0_addr[LOW_SLOT +: IDX_W] = idx;
  end

  always_comb begin
    nodev = 1'b0;
    if (cfg_reg[ADDR_W-1]) begin
      xaddr = {cfg_reg[ADDR_W-1:2], lo[1:0]};
    end else if (cfg_reg[0]) begin
      xaddr = {cfg_reg[ADDR_W-1:3], lo};
    end else begin
      xaddr = t0_addr;
      nodev = !hit;
    end
  end

  // slot field of a selected type-0 target never falls below the first select line
  always_comb begin
    if (!$isunknown(cfg_reg) && !cfg_reg[ADDR_W-1] && !cfg_reg[0] && hit) begin
      p_slot_floor_r5: assert (xaddr[LOW_SLOT +: IDX_W] >= IDX_W'(LOW_SLOT));
    end
  end
endmodule

// File: rtl/cfgx_byteswap.sv
module cfgx_byteswap #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] dout
);
  import cfgx_pkg::*;
  localparam int NB = DATA_W / 8;

  logic [DATA_W-1:0] sw_word, sw_half, sw_byte;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign sw_word[8*g +: 8] = din[8*(NB-1-g) +: 8];
    if (g < 2) begin : g_low
      assign sw_half[8*g +: 8] = din[8*(1-g) +: 8];
    end else begin : g_high
      assign sw_half[8*g +: 8] = 8'h00;
    end
    if (g == 0) begin : g_first
      assign sw_byte[7:0] = din[7:0];
    end else begin : g_rest
      assign sw_byte[8*g +: 8] = 8'h00;
    end
  end

  always_comb begin
    case (cfgx_size_e'(size))
      SZ_BYTE: dout = sw_byte;
      SZ_HALF: dout = sw_half;
      default: dout = sw_word;
    endcase
  end
endmodule

// File: rtl/cfgx_ctrl.sv
module cfgx_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hb_sel,
  input  logic              hb_win,
  input  logic              hb_we,
  input  logic [1:0]        hb_size,
  input  logic [DATA_W-1:0] hb_wdata,
  input  logic [ADDR_W-1:0] xaddr,
  input  logic              nodev,
  input  logic [DATA_W-1:0] wswap,
  input  logic [DATA_W-1:0] rswap,
  input  logic              cf_ack,
  output logic [ADDR_W-1:0] cfg_q,
  output logic [DATA_W-1:0] hb_rdata,
  output logic              hb_ready,
  output logic              cf_req,
  output logic              cf_we,
  output logic [1:0]        cf_len,
  output logic [ADDR_W-1:0] cf_addr,
  output logic [DATA_W-1:0] cf_wdata
);
  import cfgx_pkg::*;

  cfgx_state_e       st_q, st_d;
  logic              cfg_en;
  logic              rd_en;
  logic [DATA_W-1:0] rd_d, rd_q;
  logic              req_en;
  logic              we_q;
  logic [1:0]        len_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q;

  always_comb begin
    st_d   = st_q;
    cfg_en = 1'b0;
    rd_en  = 1'b0;
    rd_d   = '0;
    req_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (hb_sel) begin
          if (!hb_win) begin
            cfg_en = hb_we;
            rd_en  = 1'b1;
            rd_d   = hb_we ? hb_wdata : cfg_q;
            st_d   = ST_RESP;
          end else if (nodev) begin
            rd_en = 1'b1;
            rd_d  = '1;
            st_d  = ST_RESP;
          end else begin
            req_en = 1'b1;
            st_d   = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (cf_ack) begin
          rd_en = 1'b1;
          rd_d  = rswap;
          st_d  = ST_RESP;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= hb_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      len_q  <= 2'd0;
      addr_q <= '0;
      wd_q   <= '0;
    end else if (req_en) begin
      we_q   <= hb_we;
      len_q  <= hb_size;
      addr_q <= xaddr;
      wd_q   <= wswap;
    end
  end

  assign cf_req   = (st_q == ST_WAIT);
  assign hb_ready = (st_q == ST_RESP);
  assign hb_rdata = rd_q;
  assign cf_we    = we_q;
  assign cf_len   = len_q;
  assign cf_addr  = addr_q;
  assign cf_wdata = wd_q;

  p_req_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cf_req && !cf_ack) |=> (cf_req && $stable(cf_addr) && $stable(cf_wdata)
                             && $stable(cf_len) && $stable(cf_we)));

  p_ack_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cf_req && cf_ack) |=> (hb_ready && !cf_req));

  p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hb_ready |=> !hb_ready);

  p_nodev_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cf_req && !hb_ready && hb_sel && hb_win && nodev)
      |=> (!cf_req && hb_ready && hb_rdata == '1));

  p_len_carry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cf_req && !hb_ready && hb_sel && hb_win && !nodev)
      |=> (cf_req && cf_len == $past(hb_size) && cf_we == $past(hb_we)));

  p_cfg_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(hb_sel && !hb_win && hb_we && !cf_req && !hb_ready) |=> $stable(cfg_q));
endmodule

// File: rtl/cfgx_bridge.sv
module cfgx_bridge #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int LOW_SLOT = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hb_sel,
  input  logic              hb_win,
  input  logic              hb_we,
  input  logic [2:0]        hb_lo,
  input  logic [1:0]        hb_size,
  input  logic [DATA_W-1:0] hb_wdata,
  output logic [DATA_W-1:0] hb_rdata,
  output logic              hb_ready,
  output logic              cf_req,
  output logic              cf_we,
  output logic [1:0]        cf_len,
  output logic [ADDR_W-1:0] cf_addr,
  output logic [DATA_W-1:0] cf_wdata,
  input  logic              cf_ack,
  input  logic [DATA_W-1:0] cf_rdata
);
  logic [ADDR_W-1:0] cfg_q;
  logic [ADDR_W-1:0] xaddr;
  logic              nodev;
  logic [DATA_W-1:0] wswap, rswap;

  cfgx_addr_xlate #(.ADDR_W(ADDR_W), .LOW_SLOT(LOW_SLOT)) u_xlate (
    .cfg_reg(cfg_q), .lo(hb_lo), .xaddr(xaddr), .nodev(nodev)
  );

  cfgx_byteswap #(.DATA_W(DATA_W)) u_wswap (
    .din(hb_wdata), .size(hb_size), .dout(wswap)
  );

  cfgx_byteswap #(.DATA_W(DATA_W)) u_rswap (
    .din(cf_rdata), .size(cf_len), .dout(rswap)
  );

  cfgx_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .hb_sel(hb_sel), .hb_win(hb_win), .hb_we(hb_we), .hb_size(hb_size),
    .hb_wdata(hb_wdata), .xaddr(xaddr), .nodev(nodev),
    .wswap(wswap), .rswap(rswap), .cf_ack(cf_ack),
    .cfg_q(cfg_q), .hb_rdata(hb_rdata), .hb_ready(hb_ready),
    .cf_req(cf_req), .cf_we(cf_we), .cf_len(cf_len),
    .cf_addr(cf_addr), .cf_wdata(cf_wdata)
  );

  p_reset_idle_r2: assert property (@(posedge clk) $rose(rst_n) |-> (!cf_req && cfg_q == '0));
endmodule

// File: tb/test_cfgx_bridge.sv
module test_cfgx_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hb_sel = 1'b0, hb_win = 1'b0, hb_we = 1'b0;
  logic [2:0]  hb_lo = '0;
  logic [1:0]  hb_size = '0;
  logic [31:0] hb_wdata = '0;
  logic [31:0] hb_rdata;
  logic        hb_ready, cf_req, cf_we;
  logic [1:0]  cf_len;
  logic [31:0] cf_addr, cf_wdata;
  logic        cf_ack = 1'b0;
  logic [31:0] cf_rdata = '0;

  int nchk = 0, nfail = 0;
  int nreq = 0;
  int dly = 0;
  logic [31:0] seen_addr, seen_wdata, tgt_data;
  logic [1:0]  seen_len;
  logic        seen_we;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  cfgx_bridge i_cfgx_bridge (
    .clk(clk), .rst_n(rst_n), .hb_sel(hb_sel), .hb_win(hb_win), .hb_we(hb_we),
    .hb_lo(hb_lo), .hb_size(hb_size), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata),
    .hb_ready(hb_ready), .cf_req(cf_req), .cf_we(cf_we), .cf_len(cf_len),
    .cf_addr(cf_addr), .cf_wdata(cf_wdata), .cf_ack(cf_ack), .cf_rdata(cf_rdata)
  );

  function automatic logic [31:0] eswap(logic [31:0] d, logic [1:0] sz);
    case (sz)
      2'd0: return {24'h0, d[7:0]};
      2'd1: return {16'h0, d[7:0], d[15:8]};
      default: return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endcase
  endfunction

  function automatic logic [32:0] exlate(logic [31:0] r, logic [2:0] o);
    if (r[31]) return {1'b0, r[31:2], o[1:0]};
    if (r[0]) return {1'b0, r[31:3], o};
    for (int i = 11; i < 32; i++)
      if (r[i]) return {1'b0, 16'h0, 5'(i), r[10:8], r[7:3], o};
    return {1'b1, 32'h0};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // downstream target with 0..2 cycle latency
  initial begin
    forever begin
      @(negedge clk);
      if (cf_ack) cf_ack = 1'b0;
      else if (cf_req) begin
        if (dly == 0) begin
          seen_addr = cf_addr; seen_wdata = cf_wdata;
          seen_len = cf_len; seen_we = cf_we;
          cf_rdata = tgt_data;
          cf_ack = 1'b1;
          nreq++;
          dly = int'($urandom % 3);
        end else dly--;
      end
    end
  end

  task automatic access(logic win, logic we, logic [2:0] lo, logic [1:0] sz,
                        logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    hb_sel = 1'b1; hb_win = win; hb_we = we; hb_lo = lo; hb_size = sz; hb_wdata = wd;
    do @(negedge clk); while (!hb_ready);
    rd = hb_rdata;
    hb_sel = 1'b0;
  endtask

  initial begin
    logic [31:0] rd, reg_v, wd;
    logic [32:0] ex;
    logic [2:0]  lo;
    logic [1:0]  sz;
    int          n0;
    void'($urandom(32'h5eed));
    tgt_data = 32'h11223344;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 req low", {31'h0, cf_req}, 32'h0);
    access(1'b0, 1'b0, 3'd0, 2'd2, 32'h0, rd);
    check("R2 reg zero", rd, 32'h0);

    // R1 store and read back
    access(1'b0, 1'b1, 3'd0, 2'd2, 32'hA5C3_0F01, rd);
    access(1'b0, 1'b0, 3'd5, 2'd0, 32'h0, rd);
    check("R1 readback", rd, 32'hA5C3_0F01);
    // R1 data-window access leaves register
    n0 = nreq;
    access(1'b1, 1'b1, 3'd2, 2'd1, 32'h0000_BEEF, rd);
    access(1'b0, 1'b0, 3'd0, 2'd2, 32'h0, rd);
    check("R1 unchanged after data access", rd, 32'hA5C3_0F01);
    check("R9 one request", nreq - n0, 1);

    // directed format corners
    access(1'b0, 1'b1, 3'd0, 2'd2, 32'h8000_0abc, rd);
    access(1'b1, 1'b0, 3'd7, 2'd2, 32'h0, rd);
    check("R3 bit31 format", seen_addr, 32'h8000_0abf);
    access(1'b0, 1'b1, 3'd0, 2'd2, 32'h0012_3455, rd);
    access(1'b1, 1'b0, 3'd6, 2'd2, 32'h0, rd);
    check("R4 type1 format", seen_addr, 32'h0012_3456);
    access(1'b0, 1'b1, 3'd0, 2'd2, 32'h8400_08FC, rd);
    access(1'b1, 1'b0, 3'd1, 2'd2, 32'h0, rd);
    check("R3 priority over type0", seen_addr, 32'h8400_08FD);
    access(1'b0, 1'b1, 3'd0, 2'd2, 32'h8000_0800 & 32'h7FFF_FFFF | 32'h0002_0000 | 32'h0000_03F8, rd);
    access(1'b1, 1'b0, 3'd3, 2'd2, 32'h0, rd);
    check("R5 lowest slot wins", seen_addr, {16'h0, 5'd11, 3'd3, 5'h1F, 3'd3});
    access(1'b0, 1'b1, 3'd0, 2'd2, 32'h8000_0000 >> 0 & 32'h7FFF_FFFF | 32'h4000_0500, rd);
    access(1'b1, 1'b0, 3'd0, 2'd2, 32'h0, rd);
    check("R5 slot 30", seen_addr, {16'h0, 5'd30, 3'd5, 5'h0, 3'd0});

    // R6 no device
    access(1'b0, 1'b1, 3'd0, 2'd2, 32'h0000_07FE, rd);
    n0 = nreq;
    access(1'b1, 1'b0, 3'd0, 2'd2, 32'h0, rd);
    check("R6 nodev read ones", rd, 32'hFFFF_FFFF);
    access(1'b1, 1'b1, 3'd0, 2'd2, 32'h1234_5678, rd);
    check("R6 nodev no request", nreq - n0, 0);

    // random mix
    for (int k = 0; k < 60; k++) begin
      case ($urandom % 4)
        0: reg_v = $urandom | 32'h8000_0000;
        1: reg_v = ($urandom & 32'h7FFF_FFFF) | 32'h1;
        2: reg_v = ($urandom & 32'h7FFF_FFFE) | (32'h1 << (11 + $urandom % 20));
        default: reg_v = $urandom & 32'h0000_07FE;
      endcase
      lo = 3'($urandom); sz = 2'($urandom % 3); wd = $urandom;
      tgt_data = $urandom;
      access(1'b0, 1'b1, 3'd0, 2'd2, reg_v, rd);
      ex = exlate(reg_v, lo);
      n0 = nreq;
      if ($urandom % 2 == 1) begin
        access(1'b1, 1'b1, lo, sz, wd, rd);
        if (ex[32]) check("R6 random drop", nreq - n0, 0);
        else begin
          check("R9 random single req", nreq - n0, 1);
          check("R3/R4/R5 random addr", seen_addr, ex[31:0]);
          check("R7 write swap", seen_wdata, eswap(wd, sz));
          check("R10 len/we", {29'h0, seen_we, seen_len}, {29'h0, 1'b1, sz});
        end
      end else begin
        access(1'b1, 1'b0, lo, sz, 32'h0, rd);
        if (ex[32]) check("R6 random ones", rd, 32'hFFFF_FFFF);
        else begin
          check("R5 random addr", seen_addr, ex[31:0]);
          check("R8 read swap", rd, eswap(tgt_data, sz));
          check("R10 read we", {31'h0, seen_we}, 32'h0);
        end
      end
    end

    // R2 reset mid-request drops it
    access(1'b0, 1'b1, 3'd0, 2'd2, 32'h0000_0801, rd);
    dly = 50;
    @(negedge clk);
    hb_sel = 1'b1; hb_win = 1'b1; hb_we = 1'b0; hb_size = 2'd2;
    repeat (3) @(negedge clk);
    hb_sel = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R2 pending dropped", {31'h0, cf_req}, 32'h0);
    rst_n = 1'b1;
    dly = 0;
    @(negedge clk);
    check("R2 still idle", {30'h0, cf_req, hb_ready}, 32'h0);
    access(1'b0, 1'b0, 3'd0, 2'd2, 32'h0, rd);
    check("R2 reg cleared", rd, 32'h0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule